// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block produces the single interrupt output of a 16550-style UART. It looks at the transmit and receive data path status and does not hold any FIFO. Its inputs are the transmit and receive occupancy counts, their trigger levels, a FIFO-enable bit and a one-pulse-per-character tick. From these it forms a transmit condition and a receive condition. Each condition is gated by its own enable, and the two are ORed into one interrupt request.

A bus-style select picks how that request leaves the block. In active-high style it drives the `int_out` pin. In open-drain style it asserts `irq_oe`, a drive-low enable for an active-low request line whose idle state is released. With the FIFO-enable bit clear, the conditions follow single holding registers. With it set, they follow trigger levels, and a receive idle timer adds a timeout condition. The FIFO-enable bit is bit 0 of the UART's FIFO control register. The bus-style select is `mode_sel`: 1 selects active-high style and 0 selects open-drain style.

Top module: `uart_irq_pin_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `int_out` and `irq_oe` are 0 after that edge, and the idle timer is cleared.
- R2: With `fifo_en`=0, the transmit condition is active exactly when `tx_count`==0, meaning the holding register is empty.
- R3: With `fifo_en`=1, the transmit condition is active when `tx_count`==0 or `tx_count` < `tx_trig`.
- R4: With `fifo_en`=0, the receive condition is active exactly when `rx_count` != 0, meaning a byte is held.
- R5: With `fifo_en`=1, the receive condition is active when `rx_count` != 0 and `rx_count` >= `rx_trig`, or when the receive timeout is set.
- R6: The receive timeout sets after 4 `char_tick` pulses. These must arrive while `fifo_en`=1 and `rx_count` != 0, with no `rx_push` or `rx_pop`. The timeout never sets with the FIFO disabled or empty, and it stays set on further ticks.
- R7: An `rx_push` or `rx_pop` clears the timeout and restarts the idle count from zero.
- R8: `tx_ie` gates the transmit condition and `rx_ie` gates the receive condition, and the gated conditions are ORed. With both enables at 0, the output is inactive.
- R9: With `mode_sel`=1, `int_out` carries the request active high and `irq_oe` stays 0. With `mode_sel`=0, `irq_oe`=1 drives the active-low line low on a request and `int_out` stays 0.
- R10: The outputs are registered. They reflect the inputs sampled at the preceding clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | FIFO enable (bit 0 of the FIFO control register) |
| mode_sel | input | 1 | 1 = active-high pin, 0 = open-drain active-low line |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_count | input | CNT_W | Transmit occupancy |
| tx_trig | input | CNT_W | Transmit trigger level |
| rx_count | input | CNT_W | Receive occupancy |
| rx_trig | input | CNT_W | Receive trigger level |
| char_tick | input | 1 | One pulse per character time |
| rx_push | input | 1 | A received byte enters the receive FIFO |
| rx_pop | input | 1 | The receive FIFO is read |
| int_out | output | 1 | Active-high interrupt pin |
| irq_oe | output | 1 | Drive-low enable of the active-low request line |

## Verification
The assertions assume that the occupancy counts and trigger levels are held steady between the edges where a result is expected. They also assume that `char_tick`, `rx_push` and `rx_pop` are single-cycle pulses. The stimulus changes every input only at the falling clock edge. It sweeps the counts and trigger levels over 0 to 5 while the timer rests at zero, because no ticks are given in those sweeps. Timeout, restart and mode-change cases are then applied as separate sequences, with each pulse lasting exactly one cycle.

// File: rtl/uart_irq_pkg.sv
// Package uart_irq_pkg
// Shared type for the interrupt pin generator: selects the output signalling style.
package uart_irq_pkg;
    typedef enum logic {
        STYLE_OPEN_DRAIN  = 1'b0,
        STYLE_ACTIVE_HIGH = 1'b1
    } bus_style_e;
endpackage

// File: rtl/uart_irq_tx_cond.sv
// Module uart_irq_tx_cond
// Forms the transmit interrupt condition from the transmit occupancy.
// Assumes tx_count and tx_trig are in the same unit, which is bytes.
module uart_irq_tx_cond #(
    parameter int CNT_W = 6
) (
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_trig,
    output logic             tx_cond
);
    logic tx_empty;

    // Select holding-register or trigger-level behaviour
    always_comb begin
        tx_empty = (tx_count == '0);
        if (fifo_en) tx_cond = tx_empty || (tx_count < tx_trig);
        else         tx_cond = tx_empty;
    end
endmodule

// File: rtl/uart_irq_rx_timeout.sv
// Module uart_irq_rx_timeout
// Counts character times with no receive FIFO activity while data waits.
// Assumes char_tick, rx_push and rx_pop are single-cycle pulses.
module uart_irq_rx_timeout #(
    parameter int CNT_W         = 6,
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             char_tick,
    input  logic             rx_push,
    input  logic             rx_pop,
    output logic             rx_tmo
);
    localparam int TMO_W = $clog2(TIMEOUT_CHARS + 1);
    localparam logic [TMO_W-1:0] LIMIT = TMO_W'(TIMEOUT_CHARS);

    logic [TMO_W-1:0] idle_cnt;
    logic             restart;

    // Decide when the idle count must restart
    always_comb restart = !fifo_en || (rx_count == '0) || rx_push || rx_pop;

    // Idle character counter, saturating at the timeout limit
    always_ff @(posedge clk) begin
        if (!rst_n)                             idle_cnt <= '0;
        else if (restart)                       idle_cnt <= '0;
        else if (char_tick && idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign rx_tmo = (idle_cnt == LIMIT);
endmodule

// File: rtl/uart_irq_rx_cond.sv
// Module uart_irq_rx_cond
// Forms the receive interrupt condition from the occupancy and the timeout.
// Assumes rx_tmo is only ever set in FIFO mode.
module uart_irq_rx_cond #(
    parameter int CNT_W = 6
) (
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_tmo,
    output logic             rx_cond
);
    logic has_data;

    // Select holding-register or trigger-level behaviour
    always_comb begin
        has_data = (rx_count != '0);
        if (fifo_en) rx_cond = (has_data && (rx_count >= rx_trig)) || rx_tmo;
        else         rx_cond = has_data;
    end
endmodule

// File: rtl/uart_irq_pin_drv.sv
// Module uart_irq_pin_drv
// Gates and merges the conditions, then registers them onto the selected output style.
// Assumes mode_sel is static during normal operation.
module uart_irq_pin_drv
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic tx_ie,
    input  logic rx_ie,
    input  logic tx_cond,
    input  logic rx_cond,
    output logic int_out,
    output logic irq_oe
);
    bus_style_e style;
    logic       req;

    // Merge the enabled conditions into one request
    always_comb begin
        style = bus_style_e'(mode_sel);
        req   = (tx_ie && tx_cond) || (rx_ie && rx_cond);
    end

    // Register the request onto the pin chosen by the style
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_out <= 1'b0;
            irq_oe  <= 1'b0;
        end else begin
            int_out <= (style == STYLE_ACTIVE_HIGH) && req;
            irq_oe  <= (style == STYLE_OPEN_DRAIN)  && req;
        end
    end
endmodule

// File: rtl/uart_irq_pin_gen.sv
// Module uart_irq_pin_gen
// Top of the UART interrupt pin generator: transmit/receive conditions,
// receive idle timeout, and the style-dependent output register.
// Assumes all inputs are synchronous to clk.
module uart_irq_pin_gen #(
    parameter int CNT_W         = 6,
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             mode_sel,
    input  logic             tx_ie,
    input  logic             rx_ie,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             char_tick,
    input  logic             rx_push,
    input  logic             rx_pop,
    output logic             int_out,
    output logic             irq_oe
);
    logic tx_cond;
    logic rx_cond;
    logic rx_tmo;

    uart_irq_tx_cond #(.CNT_W(CNT_W)) i_tx_cond (
        .fifo_en (fifo_en),
        .tx_count(tx_count),
        .tx_trig (tx_trig),
        .tx_cond (tx_cond)
    );

    uart_irq_rx_timeout #(.CNT_W(CNT_W), .TIMEOUT_CHARS(TIMEOUT_CHARS)) i_rx_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .rx_count (rx_count),
        .char_tick(char_tick),
        .rx_push  (rx_push),
        .rx_pop   (rx_pop),
        .rx_tmo   (rx_tmo)
    );

    uart_irq_rx_cond #(.CNT_W(CNT_W)) i_rx_cond (
        .fifo_en (fifo_en),
        .rx_count(rx_count),
        .rx_trig (rx_trig),
        .rx_tmo  (rx_tmo),
        .rx_cond (rx_cond)
    );

    uart_irq_pin_drv i_pin_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode_sel),
        .tx_ie   (tx_ie),
        .rx_ie   (rx_ie),
        .tx_cond (tx_cond),
        .rx_cond (rx_cond),
        .int_out (int_out),
        .irq_oe  (irq_oe)
    );
endmodule

// File: rtl/uart_irq_pin_gen_chk.sv
// Module uart_irq_pin_gen_chk
// Property checker bound to uart_irq_pin_gen.
module uart_irq_pin_gen_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             mode_sel,
    input logic             tx_ie,
    input logic             rx_ie,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] tx_trig,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] rx_trig,
    input logic             char_tick,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             rx_tmo,
    input logic             int_out,
    input logic             irq_oe
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!int_out && !irq_oe));

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !fifo_en && tx_ie && tx_count == '0) |=> int_out);

    p_tx_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && fifo_en && tx_ie && tx_count < tx_trig) |=> int_out);

    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !fifo_en && rx_ie && rx_count != '0) |=> int_out);

    p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && fifo_en && rx_ie && rx_count != '0 && rx_count >= rx_trig) |=> int_out);

    p_tmo_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_tmo) |-> ($past(char_tick) && $past(fifo_en)));

    p_tmo_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !rx_tmo);

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie && !rx_ie) |=> (!int_out && !irq_oe));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_out && irq_oe));

    p_style_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> !int_out);
endmodule

bind uart_irq_pin_gen uart_irq_pin_gen_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .mode_sel (mode_sel),
    .tx_ie    (tx_ie),
    .rx_ie    (rx_ie),
    .tx_count (tx_count),
    .tx_trig  (tx_trig),
    .rx_count (rx_count),
    .rx_trig  (rx_trig),
    .char_tick(char_tick),
    .rx_push  (rx_push),
    .rx_pop   (rx_pop),
    .rx_tmo   (rx_tmo),
    .int_out  (int_out),
    .irq_oe   (irq_oe)
);

// File: tb/test_uart_irq_pin_gen.sv
// Bench for uart_irq_pin_gen: level sweeps plus timeout sequences.
module test_uart_irq_pin_gen;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b0, mode_sel = 1'b1, tx_ie = 1'b0, rx_ie = 1'b0;
    logic [CNT_W-1:0] tx_count = '0, tx_trig = '0, rx_count = '0, rx_trig = '0;
    logic             char_tick = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic             int_out, irq_oe;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    uart_irq_pin_gen #(.CNT_W(CNT_W), .TIMEOUT_CHARS(4)) i_uart_irq_pin_gen (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_sel(mode_sel),
        .tx_ie(tx_ie), .rx_ie(rx_ie), .tx_count(tx_count), .tx_trig(tx_trig),
        .rx_count(rx_count), .rx_trig(rx_trig), .char_tick(char_tick),
        .rx_push(rx_push), .rx_pop(rx_pop), .int_out(int_out), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {int_out,irq_oe} got %b expected %b", req, got, exp);
        end
    endtask

    // Expected request from the requirement formulas, without timeout
    function automatic logic exp_req(input int fe, input int tie, input int rie,
                                     input int txc, input int txt, input int rxc, input int rxt);
        logic tc, rc;
        tc = fe ? (txc == 0 || txc < txt) : (txc == 0);
        rc = fe ? (rxc != 0 && rxc >= rxt) : (rxc != 0);
        return (tie != 0 && tc) || (rie != 0 && rc);
    endfunction

    function automatic logic [1:0] pins(input logic md, input logic rq);
        return {md & rq, ~md & rq};
    endfunction

    task automatic tick_once();
        @(negedge clk) char_tick = 1'b1;
        @(negedge clk) char_tick = 1'b0;
    endtask

    task automatic pulse_pop();
        @(negedge clk) rx_pop = 1'b1;
        @(negedge clk) rx_pop = 1'b0;
    endtask

    task automatic pulse_push();
        @(negedge clk) rx_push = 1'b1;
        @(negedge clk) rx_push = 1'b0;
    endtask

    initial begin
        // R1: reset holds outputs inactive even with a request present
        mode_sel = 1'b1; tx_ie = 1'b1; tx_count = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", {int_out, irq_oe}, 2'b00);
        mode_sel = 1'b0;
        @(negedge clk);
        check("R1 reset style0", {int_out, irq_oe}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 first cycle after reset", {int_out, irq_oe}, 2'b01);

        // R2 R3 R8 R9 R10: transmit sweep, one-cycle latency
        for (int md = 0; md < 2; md++)
            for (int fe = 0; fe < 2; fe++)
                for (int ie = 0; ie < 4; ie++)
                    for (int c = 0; c < 6; c++)
                        for (int t = 0; t < 6; t++) begin
                            mode_sel = md[0]; fifo_en = fe[0];
                            tx_ie = ie[0]; rx_ie = ie[1];
                            tx_count = CNT_W'(c); tx_trig = CNT_W'(t);
                            rx_count = '0; rx_trig = '0;
                            @(negedge clk);
                            check(fe ? "R3 tx level" : "R2 tx hold",
                                  {int_out, irq_oe},
                                  pins(md[0], exp_req(fe, ie & 1, ie >> 1, c, t, 0, 0)));
                        end

        // R4 R5 R8 R9: receive sweep with transmit condition inactive
        for (int md = 0; md < 2; md++)
            for (int fe = 0; fe < 2; fe++)
                for (int ie = 0; ie < 4; ie++)
                    for (int c = 0; c < 6; c++)
                        for (int t = 0; t < 6; t++) begin
                            mode_sel = md[0]; fifo_en = fe[0];
                            tx_ie = ie[0]; rx_ie = ie[1];
                            tx_count = CNT_W'(3); tx_trig = '0;
                            rx_count = CNT_W'(c); rx_trig = CNT_W'(t);
                            @(negedge clk);
                            check(fe ? "R5 rx level" : "R4 rx hold",
                                  {int_out, irq_oe},
                                  pins(md[0], exp_req(fe, ie & 1, ie >> 1, 3, 0, c, t)));
                        end

        // R6: timeout after four idle character times
        @(negedge clk);
        mode_sel = 1'b1; fifo_en = 1'b1; tx_ie = 1'b0; rx_ie = 1'b1;
        rx_count = CNT_W'(2); rx_trig = CNT_W'(8);
        pulse_pop();
        @(negedge clk);
        check("R5 below trigger", {int_out, irq_oe}, 2'b00);
        repeat (3) tick_once();
        @(negedge clk);
        check("R6 three ticks", {int_out, irq_oe}, 2'b00);
        tick_once();
        @(negedge clk);
        check("R6 four ticks", {int_out, irq_oe}, 2'b10);
        tick_once();
        @(negedge clk);
        check("R6 saturate", {int_out, irq_oe}, 2'b10);

        // R7: read clears, push restarts the count
        pulse_pop();
        @(negedge clk);
        check("R7 pop clears", {int_out, irq_oe}, 2'b00);
        repeat (3) tick_once();
        pulse_push();
        repeat (3) tick_once();
        @(negedge clk);
        check("R7 push restarts", {int_out, irq_oe}, 2'b00);
        tick_once();
        @(negedge clk);
        check("R7 count after restart", {int_out, irq_oe}, 2'b10);

        // R9: timeout seen on the open-drain style
        mode_sel = 1'b0;
        @(negedge clk);
        check("R9 timeout open-drain", {int_out, irq_oe}, 2'b01);

        // R6: empty FIFO never times out
        rx_count = '0;
        repeat (5) tick_once();
        @(negedge clk);
        check("R6 empty no timeout", {int_out, irq_oe}, 2'b00);

        // R6: FIFO disabled never times out
        fifo_en = 1'b0; rx_count = CNT_W'(2);
        repeat (5) tick_once();
        @(negedge clk);
        check("R4 held byte", {int_out, irq_oe}, 2'b01);
        fifo_en = 1'b1;
        @(negedge clk);
        check("R6 disabled no timeout", {int_out, irq_oe}, 2'b00);

        // R8: timeout masked by rx_ie
        repeat (4) tick_once();
        rx_ie = 1'b0;
        @(negedge clk);
        check("R8 timeout masked", {int_out, irq_oe}, 2'b00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule